// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter with Match Index

This block decides whether a received CAN frame is kept, based on its identifier, and tags each kept frame with a small number that names the filter entry that let it through. The identifier arrives as a 32-bit parallel word with a one-cycle strobe. It is tested against a parameterised number of filter banks. Each bank stores eight configuration bytes. A per-bank control byte gives the bank one of three element widths: one 32-bit filter, two 16-bit filters or four 8-bit filters. The control byte also sets mask or exact-list mode separately for the lower and the upper half of the bank.

When several entries accept the same identifier, one winner is chosen by fixed rules. Exact-list entries beat mask entries. Wider elements beat narrower ones. On a full tie, the lower bank wins, and inside a bank the lower byte position wins. The result index lets receive software use the number directly as an offset into its own data table. A separate byte-wide write port loads the filter bytes and the control bytes. Filter bytes are locked while their bank is enabled.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every bank is disabled and all filter bytes are zero, so every frame is rejected; res_valid, res_accept and res_index are 0.
- R2: Each id_stb yields exactly one res_valid pulse, in the cycle after the strobe, and res_accept and res_index are meaningful in that cycle. Strobes on consecutive cycles yield consecutive pulses.
- R3: Mask mode: an element E followed by its partner mask M accepts when ((key XOR E) AND M) is zero. Only the first element of each pair consumes an index.
- R4: List mode: both elements of a pair are exact identifiers, and each one consumes its own index.
- R5: Element layout. A 32-bit element compares the whole word, with bytes 0..3 as element 0 and bytes 4..7 as element 1 (byte 0 least significant). A 16-bit element compares key bits 31:16, with words {b1,b0},{b3,b2} as the lower pair and {b5,b4},{b7,b6} as the upper pair. An 8-bit element compares key bits 31:24, with pairs (b0,b1),(b2,b3),(b4,b5),(b6,b7).
- R6: Control byte (register 8): bit0 enable, bits 2:1 width (00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = invalid), bit3 list mode for bytes 0..3, bit4 list mode for bytes 4..7. Width 11, or width 32-bit with bit3 different from bit4, is a configuration error: that bank never matches and consumes no indices.
- R7: A disabled bank never matches but still consumes its indices.
- R8: Indices are numbered from 0 upward, bank 0 first. Within a bank they follow byte position order, one per existing entry.
- R9: Among matching entries, an exact-list entry beats a mask entry, whatever the widths.
- R10: Within the same mode, a wider element beats a narrower one (32 over 16 over 8).
- R11: Same mode and width: the lower bank number wins. Inside a bank, the lower byte position wins.
- R12: If no entry matches, res_accept is 0 and res_index is 0 in the valid cycle.
- R13: Writes to filter bytes (registers 0..7) of an enabled bank are ignored. The control byte is writable at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_stb | input | 1 | Identifier word is present this cycle |
| id_word | input | 32 | Identifier word to test |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | BANK_W (2) | Bank selected by the write |
| cfg_reg | input | 4 | Register in the bank: 0..7 filter bytes, 8 control |
| cfg_data | input | 8 | Write data |
| res_valid | output | 1 | One-cycle pulse carrying a decision |
| res_accept | output | 1 | Frame accepted |
| res_index | output | IDX_W (5) | Winning filter index, 0 on reject |

## Verification
Every decision is due exactly one clock after the strobe edge: a single register stage sits between the identifier port and the three result outputs. The checks drive the strobe at a falling edge, step one full cycle, and sample at the next falling edge. They then sample once more a cycle later to confirm the pulse has ended. Configuration writes complete at the rising edge after they are driven. Every probe is therefore issued after the last write has settled, so each decision reflects the new settings.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

   localparam int ID_BITS   = 32;
   localparam int FB_BYTES  = 8;
   localparam int LIDX_W    = $clog2(FB_BYTES);
   localparam int CNT_W     = $clog2(FB_BYTES + 1);
   localparam int CTL_SEL   = FB_BYTES;

   typedef enum logic [1:0] {
      FW_8   = 2'b00,
      FW_16  = 2'b01,
      FW_32  = 2'b10,
      FW_BAD = 2'b11
   } fwidth_e;

   typedef struct packed {
      logic    hi_list;
      logic    lo_list;
      fwidth_e width;
      logic    en;
   } bank_ctl_t;

endpackage

// File: rtl/can_filt_bank.sv
module can_filt_bank
   import can_filt_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [3:0]          wr_sel,
   input  logic [7:0]          wr_data,
   input  logic [ID_BITS-1:0]  id,
   output logic                hit,
   output logic                hit_list,
   output logic [1:0]          hit_rank,
   output logic [LIDX_W-1:0]   hit_lidx,
   output logic [CNT_W-1:0]    entry_cnt
);

   bank_ctl_t                 ctl;
   logic [FB_BYTES-1:0][7:0]  fb;
   logic                      cfg_err;
   logic                      live;
   logic [FB_BYTES-1:0]       slot_exist;
   logic [FB_BYTES-1:0]       slot_match;
   logic [FB_BYTES-1:0]       slot_list;

   // storage: filter bytes lock while enabled, control always writable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
         fb  <= '0;
      end else if (wr_en) begin
         if (wr_sel == 4'(CTL_SEL))
            ctl <= bank_ctl_t'(wr_data[4:0]);
         else if (wr_sel < 4'(CTL_SEL) && !ctl.en)
            fb[wr_sel[LIDX_W-1:0]] <= wr_data;
      end
   end

   // R13
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.en |=> $stable(fb));

   always_comb begin
      cfg_err = (ctl.width == FW_BAD) ||
                (ctl.width == FW_32 && ctl.lo_list != ctl.hi_list);
      live    = ctl.en && !cfg_err;
   end

   for (genvar s = 0; s < FB_BYTES; s++) begin : g_slot
      logic lst;
      logic e8, m8, e16, m16, e32, m32;

      assign lst = (s >= FB_BYTES / 2) ? ctl.hi_list : ctl.lo_list;

      // 8-bit elements
      if (s % 2 == 0) begin : g_p8
         assign e8 = 1'b1;
         assign m8 = lst ? (id[31:24] == fb[s])
                         : (((id[31:24] ^ fb[s]) & fb[s+1]) == 8'h00);
      end else begin : g_s8
         assign e8 = lst;
         assign m8 = (id[31:24] == fb[s]);
      end

      // 16-bit elements
      if (s % 4 == 0) begin : g_p16
         assign e16 = 1'b1;
         assign m16 = lst ? (id[31:16] == {fb[s+1], fb[s]})
                          : (((id[31:16] ^ {fb[s+1], fb[s]}) &
                              {fb[s+3], fb[s+2]}) == 16'h0000);
      end else if (s % 2 == 0) begin : g_s16
         assign e16 = lst;
         assign m16 = (id[31:16] == {fb[s+1], fb[s]});
      end else begin : g_n16
         assign e16 = 1'b0;
         assign m16 = 1'b0;
      end

      // 32-bit elements
      if (s == 0) begin : g_p32
         assign e32 = 1'b1;
         assign m32 = lst ? (id == {fb[3], fb[2], fb[1], fb[0]})
                          : (((id ^ {fb[3], fb[2], fb[1], fb[0]}) &
                              {fb[7], fb[6], fb[5], fb[4]}) == 32'h0);
      end else if (s == FB_BYTES / 2) begin : g_s32
         assign e32 = lst;
         assign m32 = (id == {fb[7], fb[6], fb[5], fb[4]});
      end else begin : g_n32
         assign e32 = 1'b0;
         assign m32 = 1'b0;
      end

      always_comb begin
         slot_list[s] = lst;
         case (ctl.width)
            FW_8:    begin slot_exist[s] = e8;   slot_match[s] = m8;   end
            FW_16:   begin slot_exist[s] = e16;  slot_match[s] = m16;  end
            FW_32:   begin slot_exist[s] = e32;  slot_match[s] = m32;  end
            default: begin slot_exist[s] = 1'b0; slot_match[s] = 1'b0; end
         endcase
      end
   end

   // in-bank pick: list first, then lowest byte position
   always_comb begin
      hit      = 1'b0;
      hit_list = 1'b0;
      hit_lidx = '0;
      for (int s = 0; s < FB_BYTES; s++) begin
         if (live && slot_exist[s] && slot_match[s]) begin
            if (!hit || (slot_list[s] && !hit_list)) begin
               hit      = 1'b1;
               hit_list = slot_list[s];
               hit_lidx = LIDX_W'($countones(slot_exist &
                              ((FB_BYTES'(1) << s) - FB_BYTES'(1))));
            end
         end
      end
      hit_rank  = ctl.width;
      entry_cnt = cfg_err ? '0 : CNT_W'($countones(slot_exist));
   end

endmodule

// File: rtl/can_filt_arb.sv
module can_filt_arb
   import can_filt_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int IDX_W     = 5,
   parameter int SUM_W     = 6
) (
   input  logic [NUM_BANKS-1:0]             b_hit,
   input  logic [NUM_BANKS-1:0]             b_list,
   input  logic [NUM_BANKS-1:0][1:0]        b_rank,
   input  logic [NUM_BANKS-1:0][LIDX_W-1:0] b_lidx,
   input  logic [NUM_BANKS-1:0][CNT_W-1:0]  b_cnt,
   output logic                             win,
   output logic [IDX_W-1:0]                 win_idx,
   output logic [NUM_BANKS-1:0]             grant,
   output logic [SUM_W-1:0]                 total
);

   always_comb begin
      logic [SUM_W-1:0] base;
      logic [2:0]       best_key;
      logic [2:0]       key;
      base     = '0;
      best_key = '0;
      win      = 1'b0;
      win_idx  = '0;
      grant    = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         key = {b_list[b], b_rank[b]};
         // strict compare keeps the lower bank on a tie
         if (b_hit[b] && (!win || key > best_key)) begin
            win      = 1'b1;
            best_key = key;
            win_idx  = IDX_W'(base + SUM_W'(b_lidx[b]));
            grant    = '0;
            grant[b] = 1'b1;
         end
         base = base + SUM_W'(b_cnt[b]);
      end
      total = base;
   end

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
   import can_filt_pkg::*;
#(
   parameter int  NUM_BANKS = 4,
   localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int IDX_W     = $clog2(NUM_BANKS * FB_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               id_stb,
   input  logic [31:0]        id_word,
   input  logic               cfg_we,
   input  logic [BANK_W-1:0]  cfg_bank,
   input  logic [3:0]         cfg_reg,
   input  logic [7:0]         cfg_data,
   output logic               res_valid,
   output logic               res_accept,
   output logic [IDX_W-1:0]   res_index
);

   localparam int SUM_W = IDX_W + 1;

   if (NUM_BANKS < 1 || NUM_BANKS > 16) begin : g_bad_banks
      $error("can_accept_filter: NUM_BANKS must be 1..16");
   end
   if (ID_BITS != 32) begin : g_bad_id
      $error("can_accept_filter: identifier word must be 32 bits");
   end

   logic [NUM_BANKS-1:0]             b_hit;
   logic [NUM_BANKS-1:0]             b_list;
   logic [NUM_BANKS-1:0][1:0]        b_rank;
   logic [NUM_BANKS-1:0][LIDX_W-1:0] b_lidx;
   logic [NUM_BANKS-1:0][CNT_W-1:0]  b_cnt;
   logic                             win;
   logic [IDX_W-1:0]                 win_idx;
   logic [NUM_BANKS-1:0]             grant;
   logic [SUM_W-1:0]                 total;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      can_filt_bank u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_we && cfg_bank == BANK_W'(b)),
         .wr_sel    (cfg_reg),
         .wr_data   (cfg_data),
         .id        (id_word),
         .hit       (b_hit[b]),
         .hit_list  (b_list[b]),
         .hit_rank  (b_rank[b]),
         .hit_lidx  (b_lidx[b]),
         .entry_cnt (b_cnt[b])
      );
   end

   can_filt_arb #(
      .NUM_BANKS (NUM_BANKS),
      .IDX_W     (IDX_W),
      .SUM_W     (SUM_W)
   ) u_arb (
      .b_hit   (b_hit),
      .b_list  (b_list),
      .b_rank  (b_rank),
      .b_lidx  (b_lidx),
      .b_cnt   (b_cnt),
      .win     (win),
      .win_idx (win_idx),
      .grant   (grant),
      .total   (total)
   );

   // R11
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (win == (grant != '0)));

   // R8
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win |-> (SUM_W'(win_idx) < total));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_index  <= '0;
      end else begin
         res_valid <= id_stb;
         if (id_stb) begin
            res_accept <= win;
            res_index  <= win ? win_idx : '0;
         end
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_stb |=> res_valid);

   // R2
   valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(id_stb));

   // R12
   reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_accept) |-> (res_index == '0));

endmodule

// File: tb/can_accept_filter_test.sv
`timescale 1ns/1ps
module can_accept_filter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        id_stb = 1'b0;
   logic [31:0] id_word = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_bank = '0;
   logic [3:0]  cfg_reg = '0;
   logic [7:0]  cfg_data = '0;
   logic        res_valid;
   logic        res_accept;
   logic [4:0]  res_index;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   can_accept_filter uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .id_stb     (id_stb),
      .id_word    (id_word),
      .cfg_we     (cfg_we),
      .cfg_bank   (cfg_bank),
      .cfg_reg    (cfg_reg),
      .cfg_data   (cfg_data),
      .res_valid  (res_valid),
      .res_accept (res_accept),
      .res_index  (res_index)
   );

   // {identifier, expected accept, expected index}
   localparam int NVEC = 10;
   localparam logic [37:0] VEC [NVEC] = '{
      {32'h12345678, 1'b1, 5'd11},
      {32'h12340000, 1'b1, 5'd6},
      {32'h1F000000, 1'b1, 5'd0},
      {32'h55AA0001, 1'b1, 5'd10},
      {32'h55AB0000, 1'b1, 5'd2},
      {32'h80000000, 1'b1, 5'd1},
      {32'h77000000, 1'b1, 5'd4},
      {32'hABCD0000, 1'b1, 5'd7},
      {32'h00000000, 1'b0, 5'd0},
      {32'h66FFFFFF, 1'b1, 5'd3}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] bank, input logic [3:0] sel, input logic [7:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_bank = bank; cfg_reg = sel; cfg_data = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wr_bytes(input logic [1:0] bank, input logic [63:0] bytes);
      for (int i = 0; i < 8; i++) wr(bank, 4'(i), bytes[8*i +: 8]);
   endtask

   task automatic probe(input logic [31:0] idv, input logic ea, input logic [4:0] ei,
                        input string req);
      @(negedge clk);
      id_word = idv; id_stb = 1'b1;
      @(negedge clk);
      id_stb = 1'b0;
      chk({req, " R2 valid"}, 32'(res_valid), 32'd1);
      chk({req, " accept"}, 32'(res_accept), 32'(ea));
      chk({req, " R12 index"}, 32'(res_index), 32'(ei));
      @(negedge clk);
      chk("R2 pulse ends", 32'(res_valid), 32'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 valid", 32'(res_valid), 32'd0);
      chk("R1 accept", 32'(res_accept), 32'd0);
      chk("R1 index", 32'(res_index), 32'd0);
      probe(32'h00000000, 1'b0, 5'd0, "R1");

      // bank0: 8-bit, low half mask, high half list
      wr_bytes(2'd0, {8'h12, 8'h77, 8'h66, 8'h55, 8'hFF, 8'h80, 8'hF0, 8'h12});
      // bank1: 16-bit, low list 1234/ABCD, high mask 5500/FF00
      wr_bytes(2'd1, {8'hFF, 8'h00, 8'h55, 8'h00, 8'hAB, 8'hCD, 8'h12, 8'h34});
      // bank2: 32-bit mask 12345678 / FFFF0000
      wr_bytes(2'd2, {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78});
      // bank3: 32-bit list 55AA0001, 12345678
      wr_bytes(2'd3, {8'h12, 8'h34, 8'h56, 8'h78, 8'h55, 8'hAA, 8'h00, 8'h01});
      wr(2'd0, 4'd8, 8'h11);
      wr(2'd1, 4'd8, 8'h0B);
      wr(2'd2, 4'd8, 8'h05);
      wr(2'd3, 4'd8, 8'h1D);

      // R3 R4 R5 R8 R9 R10 R12 table walk
      for (int v = 0; v < NVEC; v++)
         probe(VEC[v][37:6], VEC[v][5], VEC[v][4:0], "R3 R4 R5 R8 R9 R10 table");

      // R2 back-to-back strobes
      @(negedge clk);
      id_word = 32'h77000000; id_stb = 1'b1;
      @(negedge clk);
      id_word = 32'hABCD0000;
      chk("R2 b2b first valid", 32'(res_valid), 32'd1);
      chk("R2 b2b first index", 32'(res_index), 32'd4);
      @(negedge clk);
      id_stb = 1'b0;
      chk("R2 b2b second valid", 32'(res_valid), 32'd1);
      chk("R2 b2b second index", 32'(res_index), 32'd7);
      @(negedge clk);
      chk("R2 b2b end", 32'(res_valid), 32'd0);

      // R13 byte write into active bank ignored
      wr(2'd0, 4'd6, 8'h99);
      probe(32'h77000000, 1'b1, 5'd4, "R13 locked byte kept");
      probe(32'h99000000, 1'b0, 5'd0, "R13 locked byte not taken");

      // R7 disable banks 0 and 1; bank3 becomes 32-bit mask
      wr(2'd0, 4'd8, 8'h10);
      wr(2'd1, 4'd8, 8'h0A);
      wr(2'd3, 4'd8, 8'h04);
      wr_bytes(2'd3, {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h12, 8'h34, 8'h56, 8'h78});
      wr(2'd3, 4'd8, 8'h05);
      probe(32'h77000000, 1'b0, 5'd0, "R7 disabled bank silent");
      // R11 equal key in banks 2 and 3: lower bank wins
      probe(32'h12345678, 1'b1, 5'd9, "R11 bank tie");

      // R6 mismatched modes in 32-bit and width code 11 both drop bank2
      wr(2'd2, 4'd8, 8'h0D);
      probe(32'h12345678, 1'b1, 5'd9, "R6 mixed-mode error, R8 renumber");
      wr(2'd2, 4'd8, 8'h07);
      probe(32'h12345678, 1'b1, 5'd9, "R6 width 11 error");

      // R13 control byte writable while enabled
      wr(2'd3, 4'd8, 8'h04);
      probe(32'h12345678, 1'b0, 5'd0, "R13 control write honoured");

      // R1 reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mid reset valid", 32'(res_valid), 32'd0);
      chk("R1 mid reset accept", 32'(res_accept), 32'd0);
      probe(32'h12345678, 1'b0, 5'd0, "R1 after reset");

      // R11 register order inside one bank: 8-bit list, both halves
      wr_bytes(2'd0, {8'h00, 8'h00, 8'h00, 8'h42, 8'h00, 8'h00, 8'h42, 8'h21});
      wr(2'd0, 4'd8, 8'h19);
      probe(32'h42000000, 1'b1, 5'd1, "R11 lower register wins");
      probe(32'h00000000, 1'b1, 5'd2, "R11 lowest of five");
      probe(32'h21FFFFFF, 1'b1, 5'd0, "R4 R8 first entry");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule